// File: doc/BRIEF.md
# Command-Response Buffer Control Registers

This block is the register front end of a command/response buffer interface to a security coprocessor. A host reaches it through a simple memory-mapped port. Each register is a 32-bit little-endian word, and the port takes accesses of 1 to 4 bytes. The block holds three kinds of state:

- Locality ownership: assigned, granted and seized.
- The ready/idle status, and a sticky fatal-error flag.
- A start/cancel handshake with a command-processing backend.

The backend gets a request with a clamped command length. It can also get a one-cycle cancel pulse, and it reports completion with an error flag. The block also reports fixed identification, buffer size and buffer address words.

The command buffer memory is not part of the block. Its header length field enters on a port. The locality of a write is carried in address bits [15:12]. The register offset is address bits [11:0]. Only locality 0 can be assigned.

Top module: `cmdbuf_ctrl_regs`

## Requirements
- R1: After reset, the registers read as follows:
  - Offset 0x000 (locality state) reads 0x80, with bit 0 ORed as in R8.
  - Offset 0x044 (control status) reads 0x2 (idle bit 1 set, fatal bit 0 clear).
  - Offset 0x030 (identification) reads 0x00025811.
  - Offset 0x034 reads the vendor parameter (default 0x0001).
  - Offsets 0x058 and 0x064 (command and response size) read BUF_BYTES (default 3968).
  - Offsets 0x05C and 0x068 (command and response address) read BASE_ADDR+0x80.
  - Offsets 0x00C (ownership status) and 0x04C (start) read 0.
- R2: In the control-request register at 0x040, the written value is masked to the access size. A value of exactly 1 clears idle (bit 1 of 0x044). A value of exactly 2 sets idle. Any other value changes nothing.
- R3: The locality-control register is at 0x008.
  - A write of 1 sets granted (bit 0 of 0x00C), clears been-seized (bit 1 of 0x00C), and sets assigned (bit 1 of 0x000).
  - A write of 2 clears assigned and granted.
  - A write of 8, or of any other value, changes nothing.
- R4: A write of exactly 1 to the start register at 0x04C is accepted only when three conditions hold: the start bit (bit 0 of 0x04C) is clear, a locality is assigned, and the write address bits [15:12] equal 0. When no locality is assigned, the active locality code is 0xFF and matches no write. An accepted start sets the start bit and raises req_valid.
- R5: The request length req_len equals the smaller of hdr_len and BUF_BYTES. req_valid and req_len stay stable until the cycle in which req_ready is high, and req_valid then drops.
- R6: A write of exactly 1 to the cancel register at 0x048 gives a one-cycle cancel pulse only while the start bit is set. Otherwise the write has no effect.
- R7: A done pulse clears the start bit. If done_err is high with it, the fatal bit (bit 0 of 0x044) is set, and it stays set until reset.
- R8: A read of offset 0x000 ORs the inverse of the established input into bit 0.
- R9: A read returns the addressed aligned word shifted right by 8 times address bits [1:0]. rdata is valid the cycle after rd_en.
- R10: Reads of unimplemented offsets, and of the write-only offsets 0x008, 0x040 and 0x048, return 0. Writes to read-only offsets are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe |
| addr | input | ADDR_W | Byte address: [15:12] locality, [11:0] offset |
| size | input | 2 | Access size in bytes minus one |
| wdata | input | 32 | Write value, right-aligned |
| rdata | output | 32 | Read data, registered |
| req_valid | output | 1 | Command request to backend |
| req_ready | input | 1 | Backend accepts request |
| req_len | output | LEN_W | Clamped command length |
| hdr_len | input | 32 | Length field from the command header |
| cancel | output | 1 | Cancel pulse to backend |
| done | input | 1 | Backend completion pulse |
| done_err | input | 1 | Completion carries an error |
| established | input | 1 | External established flag |

## Verification
The assertions assume a well-behaved backend:
- It pulses done only while a command is running, and only after it has accepted the request.
- It never raises req_ready without a pending request.

The bench plays that backend itself. It accepts each request within a few cycles of req_valid rising, and it raises done only when its own model says the start bit is set. The random host traffic mixes the following:
- Locality, control, start and cancel writes with both legal and arbitrary values.
- Foreign localities.
- All four access sizes.
- Reads at arbitrary byte lanes.

// File: rtl/cmdbuf_pkg.sv
package cmdbuf_pkg;
   localparam int OFS_W = 12;

   localparam logic [OFS_W-1:0] OFS_LOC_STATE = 12'h000;
   localparam logic [OFS_W-1:0] OFS_LOC_CTRL  = 12'h008;
   localparam logic [OFS_W-1:0] OFS_LOC_STS   = 12'h00C;
   localparam logic [OFS_W-1:0] OFS_IF_ID     = 12'h030;
   localparam logic [OFS_W-1:0] OFS_IF_VEND   = 12'h034;
   localparam logic [OFS_W-1:0] OFS_CTRL_REQ  = 12'h040;
   localparam logic [OFS_W-1:0] OFS_CTRL_STS  = 12'h044;
   localparam logic [OFS_W-1:0] OFS_CANCEL    = 12'h048;
   localparam logic [OFS_W-1:0] OFS_START     = 12'h04C;
   localparam logic [OFS_W-1:0] OFS_CMD_SIZE  = 12'h058;
   localparam logic [OFS_W-1:0] OFS_CMD_ADDR  = 12'h05C;
   localparam logic [OFS_W-1:0] OFS_RSP_SIZE  = 12'h064;
   localparam logic [OFS_W-1:0] OFS_RSP_ADDR  = 12'h068;
   localparam logic [OFS_W-1:0] OFS_DATA      = 12'h080;

   localparam logic [31:0] LOC_CMD_REQUEST = 32'd1;
   localparam logic [31:0] LOC_CMD_RELEASE = 32'd2;
   localparam logic [31:0] CTRL_CMD_READY  = 32'd1;
   localparam logic [31:0] CTRL_CMD_IDLE   = 32'd2;
   localparam logic [31:0] CMD_INVOKE      = 32'd1;

   localparam logic [7:0] NO_LOCALITY = 8'hFF;

   typedef struct packed {
      logic assigned;
      logic granted;
      logic seized;
   } own_state_t;

   function automatic logic [31:0] build_if_id();
      logic [31:0] v;
      v        = '0;
      v[3:0]   = 4'd1;   // buffer interface active
      v[7:4]   = 4'd1;   // interface version 1
      v[8]     = 1'b0;   // single locality
      v[9]     = 1'b0;   // fast idle
      v[12:11] = 2'b11;  // transfer size code
      v[13]    = 1'b0;   // no FIFO interface
      v[14]    = 1'b1;   // buffer interface supported
      v[18:17] = 2'b01;  // selector
      v[27:24] = 4'd0;   // revision
      return v;
   endfunction
endpackage

// File: rtl/cmdbuf_locality.sv
module cmdbuf_locality
   import cmdbuf_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        ctrl_wr,
   input  logic [31:0] wval,
   output own_state_t  own
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         own <= '0;
      end else if (ctrl_wr) begin
         if (wval == LOC_CMD_REQUEST) begin
            own.granted  <= 1'b1;
            own.seized   <= 1'b0;
            own.assigned <= 1'b1;
         end else if (wval == LOC_CMD_RELEASE) begin
            own.assigned <= 1'b0;
            own.granted  <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/cmdbuf_handshake.sv
module cmdbuf_handshake
   import cmdbuf_pkg::*;
#(
   parameter int BUF_BYTES = 3968,
   parameter int LEN_W     = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctrl_wr,
   input  logic             start_wr,
   input  logic             cancel_wr,
   input  logic [31:0]      wval,
   input  logic             loc_ok,
   input  logic             req_ready,
   input  logic [31:0]      hdr_len,
   input  logic             done,
   input  logic             done_err,
   output logic             idle,
   output logic             fatal,
   output logic             start_bit,
   output logic             req_valid,
   output logic [LEN_W-1:0] req_len,
   output logic             cancel
);
   localparam logic [31:0]      BUF_W32 = 32'(BUF_BYTES);
   localparam logic [LEN_W-1:0] BUF_LEN = LEN_W'(BUF_BYTES);

   logic             accept;
   logic [LEN_W-1:0] clamped;

   assign accept  = start_wr && (wval == CMD_INVOKE) && !start_bit && loc_ok;
   assign clamped = (hdr_len > BUF_W32) ? BUF_LEN : hdr_len[LEN_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idle      <= 1'b1;
         fatal     <= 1'b0;
         start_bit <= 1'b0;
         req_valid <= 1'b0;
         req_len   <= '0;
         cancel    <= 1'b0;
      end else begin
         cancel <= cancel_wr && (wval == CMD_INVOKE) && start_bit;
         if (ctrl_wr) begin
            if (wval == CTRL_CMD_READY)     idle <= 1'b0;
            else if (wval == CTRL_CMD_IDLE) idle <= 1'b1;
         end
         if (req_valid && req_ready) req_valid <= 1'b0;
         if (done) begin
            start_bit <= 1'b0;
            if (done_err) fatal <= 1'b1;
         end else if (accept) begin
            start_bit <= 1'b1;
            req_valid <= 1'b1;
            req_len   <= clamped;
         end
      end
   end
endmodule

// File: rtl/cmdbuf_rdport.sv
module cmdbuf_rdport #(
   parameter bit REG_READ = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        rd_en,
   input  logic [31:0] word,
   input  logic [1:0]  lane,
   output logic [31:0] rdata
);
   logic [31:0] shifted;
   assign shifted = word >> {lane, 3'b000};

   if (REG_READ) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     rdata <= '0;
         else if (rd_en) rdata <= shifted;
      end
   end else begin : g_comb
      assign rdata = rd_en ? shifted : '0;
   end
endmodule

// File: rtl/cmdbuf_ctrl_regs.sv
module cmdbuf_ctrl_regs
   import cmdbuf_pkg::*;
#(
   parameter int          ADDR_W    = 16,
   parameter int          BUF_BYTES = 3968,
   parameter logic [31:0] BASE_ADDR = 32'h4000_0000,
   parameter logic [15:0] IF_VENDOR = 16'h0001,
   parameter bit          REG_READ  = 1'b1,
   parameter int          LEN_W     = $clog2(BUF_BYTES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [1:0]        size,
   input  logic [31:0]       wdata,
   output logic [31:0]       rdata,
   output logic              req_valid,
   input  logic              req_ready,
   output logic [LEN_W-1:0]  req_len,
   input  logic [31:0]       hdr_len,
   output logic              cancel,
   input  logic              done,
   input  logic              done_err,
   input  logic              established
);
   localparam int          LOC_LSB    = OFS_W;
   localparam logic [31:0] BUF_ADDR   = BASE_ADDR + 32'(OFS_DATA);
   localparam logic [31:0] BUF_SIZE   = 32'(BUF_BYTES);
   localparam logic [31:0] IF_ID      = build_if_id();
   localparam logic [3:0]  ACTIVE_LOC = 4'd0;

   if (ADDR_W < LOC_LSB + 4) begin : g_bad_addr
      $error("ADDR_W must cover the locality field");
   end
   if (BUF_BYTES < 16 || BUF_BYTES > (1 << OFS_W) - int'(OFS_DATA)) begin : g_bad_buf
      $error("BUF_BYTES out of range");
   end
   if (LEN_W < $clog2(BUF_BYTES + 1)) begin : g_bad_len
      $error("LEN_W too narrow for BUF_BYTES");
   end

   logic [OFS_W-1:0] ofs;
   logic [31:0]      wmask, wval, word;
   logic [7:0]       active_code;
   own_state_t       own;
   logic             loc_assigned, loc_granted;
   logic             idle_bit, fatal_bit, start_bit;

   assign ofs = addr[OFS_W-1:0];

   always_comb begin
      unique case (size)
         2'd0:    wmask = 32'h0000_00FF;
         2'd1:    wmask = 32'h0000_FFFF;
         2'd2:    wmask = 32'h00FF_FFFF;
         default: wmask = 32'hFFFF_FFFF;
      endcase
   end
   assign wval = wdata & wmask;

   assign loc_assigned = own.assigned;
   assign loc_granted  = own.granted;
   assign active_code  = loc_assigned ? {4'd0, ACTIVE_LOC} : NO_LOCALITY;

   cmdbuf_locality u_loc (
      .clk     (clk),
      .rst_n   (rst_n),
      .ctrl_wr (wr_en && ofs == OFS_LOC_CTRL),
      .wval    (wval),
      .own     (own)
   );

   cmdbuf_handshake #(.BUF_BYTES(BUF_BYTES), .LEN_W(LEN_W)) u_hs (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctrl_wr   (wr_en && ofs == OFS_CTRL_REQ),
      .start_wr  (wr_en && ofs == OFS_START),
      .cancel_wr (wr_en && ofs == OFS_CANCEL),
      .wval      (wval),
      .loc_ok    (active_code == {4'd0, addr[LOC_LSB+3:LOC_LSB]}),
      .req_ready (req_ready),
      .hdr_len   (hdr_len),
      .done      (done),
      .done_err  (done_err),
      .idle      (idle_bit),
      .fatal     (fatal_bit),
      .start_bit (start_bit),
      .req_valid (req_valid),
      .req_len   (req_len),
      .cancel    (cancel)
   );

   always_comb begin
      unique case ({ofs[OFS_W-1:2], 2'b00})
         OFS_LOC_STATE: word = {24'd0, 1'b1, 1'b0, ACTIVE_LOC, loc_assigned, ~established};
         OFS_LOC_STS:   word = {30'd0, own.seized, loc_granted};
         OFS_IF_ID:     word = IF_ID;
         OFS_IF_VEND:   word = {16'd0, IF_VENDOR};
         OFS_CTRL_STS:  word = {30'd0, idle_bit, fatal_bit};
         OFS_START:     word = {31'd0, start_bit};
         OFS_CMD_SIZE:  word = BUF_SIZE;
         OFS_CMD_ADDR:  word = BUF_ADDR;
         OFS_RSP_SIZE:  word = BUF_SIZE;
         OFS_RSP_ADDR:  word = BUF_ADDR;
         default:       word = '0;
      endcase
   end

   cmdbuf_rdport #(.REG_READ(REG_READ)) u_rd (
      .clk   (clk),
      .rst_n (rst_n),
      .rd_en (rd_en),
      .word  (word),
      .lane  (ofs[1:0]),
      .rdata (rdata)
   );
endmodule

// File: rtl/cmdbuf_ctrl_regs_chk.sv
module cmdbuf_ctrl_regs_chk #(
   parameter int BUF_BYTES = 3968,
   parameter int LEN_W     = 12
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic             req_ready,
   input logic [LEN_W-1:0] req_len,
   input logic             cancel,
   input logic             done,
   input logic             start_bit,
   input logic             fatal_bit,
   input logic             loc_assigned,
   input logic             loc_granted
);
   // R4
   start_needs_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req_valid) |-> $past(loc_assigned) && start_bit);
   // R5
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !req_ready |=> req_valid && $stable(req_len));
   // R5
   req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready |=> !req_valid);
   // R5
   req_len_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> 32'(req_len) <= 32'(BUF_BYTES));
   // R6
   cancel_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cancel |-> $past(start_bit));
   // R6
   cancel_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cancel |=> !cancel);
   // R7
   done_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !start_bit);
   // R7
   fatal_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fatal_bit |=> fatal_bit);
   // R3
   granted_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
      loc_granted |-> loc_assigned);
endmodule

bind cmdbuf_ctrl_regs cmdbuf_ctrl_regs_chk #(.BUF_BYTES(BUF_BYTES), .LEN_W(LEN_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_valid    (req_valid),
   .req_ready    (req_ready),
   .req_len      (req_len),
   .cancel       (cancel),
   .done         (done),
   .start_bit    (start_bit),
   .fatal_bit    (fatal_bit),
   .loc_assigned (loc_assigned),
   .loc_granted  (loc_granted)
);

// File: tb/cmdbuf_ctrl_regs_tb.sv
module cmdbuf_ctrl_regs_tb;
   localparam int          BUF  = 3968;
   localparam int          LW   = 12;
   localparam logic [31:0] BADR = 32'h4000_0080;

   logic clk = 0, rst_n = 0;
   logic wr_en = 0, rd_en = 0, req_ready = 0, done = 0, done_err = 0, est = 1;
   logic [15:0] addr = 0;
   logic [1:0] size = 0;
   logic [31:0] wdata = 0, rdata, hdr_len = 0;
   logic req_valid, cancel;
   logic [LW-1:0] req_len;

   int n_chk = 0, n_fail = 0;
   bit finished = 0;

   logic m_asg = 0, m_grt = 0, m_idle = 1, m_fatal = 0, m_start = 0;

   always #5 clk = ~clk;

   cmdbuf_ctrl_regs u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .size(size), .wdata(wdata), .rdata(rdata), .req_valid(req_valid),
      .req_ready(req_ready), .req_len(req_len), .hdr_len(hdr_len),
      .cancel(cancel), .done(done), .done_err(done_err), .established(est)
   );

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, got, exp);
      end
   endtask

   function automatic logic [31:0] exp_word(input logic [11:0] o);
      case ({o[11:2], 2'b00})
         12'h000: return {24'd0, 1'b1, 5'd0, m_asg, ~est};
         12'h00C: return {31'd0, m_grt};
         12'h030: return 32'h0002_5811;
         12'h034: return 32'h0000_0001;
         12'h044: return {30'd0, m_idle, m_fatal};
         12'h04C: return {31'd0, m_start};
         12'h058, 12'h064: return BUF;
         12'h05C, 12'h068: return BADR;
         default: return 32'd0;
      endcase
   endfunction

   function automatic logic [31:0] mask_of(input logic [1:0] s, input logic [31:0] d);
      return d & (32'hFFFF_FFFF >> (8 * (3 - s)));
   endfunction

   task automatic wr(input logic [15:0] a, input logic [31:0] d, input logic [1:0] s);
      @(negedge clk);
      wr_en = 1; addr = a; wdata = d; size = s;
      @(posedge clk); #1;
      wr_en = 0;
   endtask

   task automatic rd(input logic [15:0] a, output logic [31:0] v);
      @(negedge clk);
      rd_en = 1; addr = a;
      @(posedge clk); #1;
      rd_en = 0; v = rdata;
   endtask

   task automatic rd_chk(input string tag, input logic [11:0] o);
      logic [31:0] v;
      rd({4'd0, o}, v);
      check(tag, v, exp_word(o) >> (8 * o[1:0]));
   endtask

   task automatic do_loc(input logic [31:0] d, input logic [1:0] s);
      logic [31:0] v;
      v = mask_of(s, d);
      wr(16'h0008, d, s);
      if (v == 1) begin m_asg = 1; m_grt = 1; end
      else if (v == 2) begin m_asg = 0; m_grt = 0; end
      rd_chk("R3", 12'h00C);
      rd_chk("R3", 12'h000);
   endtask

   task automatic do_ctrl(input logic [31:0] d, input logic [1:0] s);
      logic [31:0] v;
      v = mask_of(s, d);
      wr(16'h0040, d, s);
      if (v == 1) m_idle = 0;
      else if (v == 2) m_idle = 1;
      rd_chk("R2", 12'h044);
   endtask

   task automatic do_start(input logic [3:0] loc, input logic [31:0] d, input logic [1:0] s,
                           input logic [31:0] hl, input int hold);
      bit acc;
      logic [31:0] exp_len;
      acc = (mask_of(s, d) == 1) && !m_start && m_asg && (loc == 0);
      exp_len = (hl > BUF) ? BUF : hl;
      hdr_len = hl;
      wr({loc, 12'h04C}, d, s);
      check("R4", {31'd0, req_valid}, {31'd0, acc});
      if (acc) begin
         m_start = 1;
         check("R5", {20'd0, req_len}, exp_len);
         for (int i = 0; i < hold; i++) begin
            @(posedge clk); #1;
            check("R5", {31'd0, req_valid}, 32'd1);
            check("R5", {20'd0, req_len}, exp_len);
         end
         @(negedge clk); req_ready = 1;
         @(posedge clk); #1; req_ready = 0;
         check("R5", {31'd0, req_valid}, 32'd0);
      end
      rd_chk("R4", 12'h04C);
   endtask

   task automatic do_cancel(input logic [31:0] d, input logic [1:0] s);
      bit exp;
      exp = (mask_of(s, d) == 1) && m_start;
      wr(16'h0048, d, s);
      check("R6", {31'd0, cancel}, {31'd0, exp});
      @(posedge clk); #1;
      check("R6", {31'd0, cancel}, 32'd0);
      rd_chk("R6", 12'h04C);
   endtask

   task automatic do_done(input logic err);
      @(negedge clk); done = 1; done_err = err;
      @(posedge clk); #1; done = 0; done_err = 0;
      m_start = 0;
      if (err) m_fatal = 1;
      rd_chk("R7", 12'h04C);
      rd_chk("R7", 12'h044);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_fail++; n_chk++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1;

      // R1 reset values
      foreach (v[i]) ;
      rd_chk("R1", 12'h000); rd_chk("R1", 12'h00C); rd_chk("R1", 12'h030);
      rd_chk("R1", 12'h034); rd_chk("R1", 12'h044); rd_chk("R1", 12'h04C);
      rd_chk("R1", 12'h058); rd_chk("R1", 12'h05C); rd_chk("R1", 12'h064);
      rd_chk("R1", 12'h068);

      // R8 established flag
      est = 0; rd_chk("R8", 12'h000);
      est = 1; rd_chk("R8", 12'h000);

      // R9 byte and halfword lanes
      rd_chk("R9", 12'h031); rd_chk("R9", 12'h032); rd_chk("R9", 12'h05D);

      // R10 unimplemented, write-only and read-only offsets
      rd_chk("R10", 12'h0F0); rd_chk("R10", 12'h008); rd_chk("R10", 12'h040);
      wr(16'h0058, 32'h1234, 2'd3); rd_chk("R10", 12'h058);
      wr(16'h0030, 32'h0, 2'd3);    rd_chk("R10", 12'h030);

      // R4 start without ownership, then wrong locality
      do_start(4'd0, 1, 2'd3, 64, 0);
      do_loc(32'd8, 2'd3);
      do_loc(32'd1, 2'd0);
      do_start(4'd3, 1, 2'd3, 64, 0);
      // R6 cancel while idle
      do_cancel(1, 2'd3);
      // R5 clamp and hold
      do_start(4'd0, 1, 2'd3, 32'h0001_0000, 2);
      do_start(4'd0, 1, 2'd3, 16, 0);
      do_cancel(1, 2'd1);
      do_cancel(3, 2'd3);
      do_done(1'b1);
      do_ctrl(1, 2'd3); do_ctrl(5, 2'd3); do_ctrl(2, 2'd0);
      do_start(4'd0, 1, 2'd3, 100, 1);
      do_done(1'b0);
      rd_chk("R7", 12'h044);
      do_loc(32'd2, 2'd3);

      // random traffic
      for (int it = 0; it < 600; it++) begin
         int op;
         op = $urandom_range(0, 6);
         case (op)
            0: begin
               int p;
               p = $urandom_range(0, 3);
               do_loc(p == 0 ? 32'd1 : p == 1 ? 32'd2 : p == 2 ? 32'd8 : $urandom,
                      2'($urandom_range(0, 3)));
            end
            1: begin
               int p;
               p = $urandom_range(0, 2);
               do_ctrl(p == 0 ? 32'd1 : p == 1 ? 32'd2 : $urandom, 2'($urandom_range(0, 3)));
            end
            2: do_start(($urandom_range(0, 3) == 0) ? 4'($urandom_range(1, 15)) : 4'd0,
                        ($urandom_range(0, 4) == 0) ? $urandom : 32'd1,
                        2'($urandom_range(0, 3)), $urandom_range(0, 5000),
                        $urandom_range(0, 2));
            3: do_cancel(($urandom_range(0, 3) == 0) ? $urandom : 32'd1,
                         2'($urandom_range(0, 3)));
            4: if (m_start) do_done(($urandom_range(0, 7) == 0));
            5: begin est = ~est; rd_chk("R8", 12'h000); end
            default: begin
               logic [11:0] o;
               o = ($urandom_range(0, 3) == 0) ? 12'($urandom_range(0, 255))
                                               : 12'($urandom_range(0, 27) * 4);
               rd_chk("R9", o);
            end
         endcase
      end

      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule